// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block holds an 8-bit accumulator and an 8-bit status word. In a single cycle it adds a second operand to the accumulator, adds it together with the current carry, or subtracts it together with a borrow. The result goes back into the accumulator. The same edge sets or clears the carry, the half-carry (nibble carry) and the signed-overflow flags.

A parity flag in the status word always reflects the accumulator. It follows every accumulator change, including plain loads. The status word also holds a free user flag and a two-bit register-bank select. Software can overwrite these, and also the arithmetic flags, through a direct status-word write port.

Opcode encoding on `alu_op`: 2'b00 no operation, 2'b01 add, 2'b10 add with carry, 2'b11 subtract with borrow.

Status-word layout, from bit 7 down to bit 0:
- bit 7: carry
- bit 6: half-carry
- bit 5: user flag
- bits 4..3: bank select, where bit 4 is the high bit of `bank_o`
- bit 2: overflow
- bit 1: unused, reads 0
- bit 0: parity

Top module: `accalu_top`

## Requirements
- R1: While `rst` is high on a clock edge, the accumulator and the status-word bits 7..1 clear to 0. Parity then reads 0.
- R2: An add (`alu_op`=01) loads the accumulator with (A + operand) mod 256. Carry (bit 7) is set exactly when the true sum exceeds 255.
- R3: An add with carry (`alu_op`=10) loads (A + operand + carry) mod 256. Carry is set exactly when A + operand + carry exceeds 255.
- R4: A subtract with borrow (`alu_op`=11) loads (A - operand - carry) mod 256. Carry is set exactly when A < operand + carry.
- R5: Half-carry (bit 6) is set exactly when the low nibbles of the operation carry into bit 4 (add forms) or borrow from bit 4 (subtract), counting the carry input.
- R6: Overflow (bit 2) is set exactly when the result, read as two's complement, lies outside -128..127.
- R7: Parity (bit 0 and `par_o`) is 1 exactly when the accumulator holds an odd number of ones (0xCC gives 0). It follows plain accumulator loads in the same cycle the accumulator changes.
- R8: With no arithmetic operation, `psw_we` copies `psw_wdata` bits 7..2 into the status word. Bit 0 of the write is ignored, and bit 1 always reads 0.
- R9: In a cycle with neither an arithmetic operation nor a status write, all stored flags keep their values. This holds even when the accumulator is loaded through `acc_we`.
- R10: When a status write and an arithmetic operation fall in the same cycle, carry, half-carry and overflow take the arithmetic values. User flag and bank select take the written values.
- R11: When `acc_we` and an arithmetic operation fall in the same cycle, the accumulator takes the arithmetic result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_op | input | 2 | Operation select (00 none, 01 add, 10 add with carry, 11 subtract with borrow) |
| opnd | input | 8 | Second operand |
| acc_we | input | 1 | Plain accumulator load enable |
| acc_wdata | input | 8 | Plain accumulator load value |
| psw_we | input | 1 | Status-word write enable |
| psw_wdata | input | 8 | Status-word write value |
| acc_q | output | 8 | Accumulator |
| psw_q | output | 8 | Status word |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Half-carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Accumulator parity |
| f0_o | output | 1 | User flag |
| bank_o | output | 2 | Register-bank select |

## Verification
The hardest situation to create is the collision of a status write with an arithmetic operation in the same cycle. Only the flag bits must ignore the written value there, while the user flag and bank bits must take it. Random stimulus raises `psw_we`, `acc_we` and an opcode independently, so all three overlap often.

Directed cases cover the other hard spots:
- an add of 0xFF and 0x01, which carries out of both nibble and byte;
- 0x7F + 1 and 0x80 - 1 at the signed boundary;
- a subtract of zero with carry set, which underflows to 0xFF.

These are followed by a plain load of 0xCC, which gives even parity with the flags held.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ADD  = 2'b01,
    OP_ADDC = 2'b10,
    OP_SUBB = 2'b11
  } alu_op_e;

  localparam int PSW_W   = 8;
  localparam int B_CY    = 7;
  localparam int B_AC    = 6;
  localparam int B_F0    = 5;
  localparam int B_BANKH = 4;
  localparam int B_BANKL = 3;
  localparam int B_OV    = 2;
  localparam int B_PAR   = 0;
endpackage

// File: rtl/accalu_adder.sv
module accalu_adder
  import accalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_in,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  localparam int LOW_W = DATA_W - 1;

  logic              sub;
  logic              cin;
  logic [DATA_W-1:0] b_eff;
  logic [NIB_W:0]    nib_sum;
  logic [LOW_W:0]    low_sum;
  logic [DATA_W:0]   full_sum;

  always_comb begin
    sub   = (op == OP_SUBB);
    b_eff = sub ? ~b : b;
    case (op)
      OP_ADDC: cin = cy_in;
      OP_SUBB: cin = ~cy_in;
      default: cin = 1'b0;
    endcase
    nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    res      = full_sum[DATA_W-1:0];
    cy       = sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
    ac       = sub ? ~nib_sum[NIB_W] : nib_sum[NIB_W];
    ov       = low_sum[LOW_W] ^ full_sum[DATA_W];
  end
endmodule

// File: rtl/accalu_acc.sv
module accalu_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arith_en,
  input  logic [DATA_W-1:0] arith_res,
  input  logic              mov_en,
  input  logic [DATA_W-1:0] mov_data,
  output logic [DATA_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (arith_en) acc_q <= arith_res;
    else if (mov_en)   acc_q <= mov_data;
  end
endmodule

// File: rtl/accalu_status.sv
module accalu_status
  import accalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arith_en,
  input  logic              cy_new,
  input  logic              ac_new,
  input  logic              ov_new,
  input  logic              wr_en,
  input  logic [PSW_W-1:0]  wr_data,
  input  logic [DATA_W-1:0] acc,
  output logic [PSW_W-1:0]  psw_q
);
  logic cy_r, ac_r, f0_r, ov_r;
  logic [1:0] bank_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_r   <= 1'b0;
      ac_r   <= 1'b0;
      ov_r   <= 1'b0;
      f0_r   <= 1'b0;
      bank_r <= 2'b00;
    end else begin
      if (arith_en) begin
        cy_r <= cy_new;
        ac_r <= ac_new;
        ov_r <= ov_new;
      end else if (wr_en) begin
        cy_r <= wr_data[B_CY];
        ac_r <= wr_data[B_AC];
        ov_r <= wr_data[B_OV];
      end
      if (wr_en) begin
        f0_r   <= wr_data[B_F0];
        bank_r <= wr_data[B_BANKH:B_BANKL];
      end
    end
  end

  always_comb begin
    psw_q                = '0;
    psw_q[B_CY]          = cy_r;
    psw_q[B_AC]          = ac_r;
    psw_q[B_F0]          = f0_r;
    psw_q[B_BANKH:B_BANKL] = bank_r;
    psw_q[B_OV]          = ov_r;
    psw_q[B_PAR]         = ^acc;
  end
endmodule

// File: rtl/accalu_top.sv
module accalu_top
  import accalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        alu_op,
  input  logic [DATA_W-1:0] opnd,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              psw_we,
  input  logic [PSW_W-1:0]  psw_wdata,
  output logic [DATA_W-1:0] acc_q,
  output logic [PSW_W-1:0]  psw_q,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              par_o,
  output logic              f0_o,
  output logic [1:0]        bank_o
);
  alu_op_e           op;
  logic              arith_en;
  logic [DATA_W-1:0] sum;
  logic              cy_n, ac_n, ov_n;

  assign op       = alu_op_e'(alu_op);
  assign arith_en = (op != OP_NONE);

  accalu_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
    .a(acc_q), .b(opnd), .cy_in(psw_q[B_CY]), .op(op),
    .res(sum), .cy(cy_n), .ac(ac_n), .ov(ov_n)
  );

  accalu_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .arith_en(arith_en), .arith_res(sum),
    .mov_en(acc_we), .mov_data(acc_wdata), .acc_q(acc_q)
  );

  accalu_status #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst(rst), .arith_en(arith_en), .cy_new(cy_n),
    .ac_new(ac_n), .ov_new(ov_n), .wr_en(psw_we), .wr_data(psw_wdata),
    .acc(acc_q), .psw_q(psw_q)
  );

  assign cy_o   = psw_q[B_CY];
  assign ac_o   = psw_q[B_AC];
  assign ov_o   = psw_q[B_OV];
  assign par_o  = psw_q[B_PAR];
  assign f0_o   = psw_q[B_F0];
  assign bank_o = psw_q[B_BANKH:B_BANKL];

  AST_PARITY_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (rst) par_o == ^acc_q); // R7
  AST_ARITH_FLAGS: assert property (@(posedge clk) disable iff (rst) arith_en |=> (cy_o == $past(cy_n) && ac_o == $past(ac_n) && ov_o == $past(ov_n))); // R10
  AST_ARITH_WINS_ACC: assert property (@(posedge clk) disable iff (rst) arith_en |=> acc_q == $past(sum)); // R11
  AST_PSW_WRITE: assert property (@(posedge clk) disable iff (rst) (psw_we && !arith_en) |=> psw_q[PSW_W-1:1] == {$past(psw_wdata[PSW_W-1:2]), 1'b0}); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) (!psw_we && !arith_en) |=> $stable(psw_q[PSW_W-1:1])); // R9
  AST_MOVE_LOADS: assert property (@(posedge clk) disable iff (rst) (acc_we && !arith_en) |=> acc_q == $past(acc_wdata)); // R7
endmodule

// File: tb/sim_accalu_top.sv
module sim_accalu_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] alu_op;
  logic [7:0] opnd, acc_wdata, psw_wdata;
  logic       acc_we, psw_we;
  logic [7:0] acc_q, psw_q;
  logic       cy_o, ac_o, ov_o, par_o, f0_o;
  logic [1:0] bank_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_acc;
  logic [7:0] m_psw;

  always #10 clk = ~clk;

  accalu_top u0 (
    .clk(clk), .rst(rst), .alu_op(alu_op), .opnd(opnd), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .acc_q(acc_q), .psw_q(psw_q), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
    .par_o(par_o), .f0_o(f0_o), .bank_o(bank_o)
  );

  function automatic logic odd8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n[0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] b, input logic awe,
                      input logic [7:0] ad, input logic pwe, input logic [7:0] pd,
                      input string req);
    int a, c, r, sa, sb, sr;
    logic cy, ac, ov;
    alu_op = op; opnd = b; acc_we = awe; acc_wdata = ad; psw_we = pwe; psw_wdata = pd;
    @(posedge clk);
    a = int'(m_acc); c = int'(m_psw[7]);
    sa = a > 127 ? a - 256 : a;
    sb = int'(b) > 127 ? int'(b) - 256 : int'(b);
    if (op != 2'b00) begin
      if (op == 2'b11) begin
        r  = a - int'(b) - c;
        cy = (a < int'(b) + c);
        ac = ((a % 16) < (int'(b) % 16) + c);
        sr = sa - sb - c;
      end else begin
        if (op == 2'b01) c = 0;
        r  = a + int'(b) + c;
        cy = (r > 255);
        ac = ((a % 16) + (int'(b) % 16) + c > 15);
        sr = sa + sb + c;
      end
      ov = (sr > 127) || (sr < -128);
      m_acc = 8'(r);
      m_psw[7] = cy; m_psw[6] = ac; m_psw[2] = ov;
      if (pwe) m_psw[5:3] = pd[5:3];
    end else begin
      if (pwe) begin m_psw[7:2] = pd[7:2]; end
      if (awe) m_acc = ad;
    end
    m_psw[1] = 1'b0;
    m_psw[0] = odd8(m_acc);
    @(negedge clk);
    chk({req, " acc"}, {8'h0, acc_q}, {8'h0, m_acc});
    chk({req, " psw"}, {8'h0, psw_q}, {8'h0, m_psw});
    chk({req, " pins"}, {10'h0, cy_o, ac_o, ov_o, par_o, f0_o, bank_o[1]},
        {10'h0, m_psw[7], m_psw[6], m_psw[2], m_psw[0], m_psw[5], m_psw[4]});
    alu_op = 2'b00; acc_we = 1'b0; psw_we = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; alu_op = 2'b00; opnd = 8'h0; acc_we = 1'b0; acc_wdata = 8'h0;
    psw_we = 1'b0; psw_wdata = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", {8'h0, acc_q}, 16'h0000);
    chk("R1 psw", {8'h0, psw_q}, 16'h0000);
    rst = 1'b0;
    m_acc = 8'h00; m_psw = 8'h00;

    // R2 R5 R7: 0xFF + 0x01 carries out of nibble and byte, result 0 even parity
    step(2'b00, 8'h00, 1'b1, 8'hFF, 1'b0, 8'h00, "R7 move 0xFF");
    step(2'b01, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R2 R5 add FF+1");
    // R6 signed overflow 0x7F + 1
    step(2'b00, 8'h00, 1'b1, 8'h7F, 1'b0, 8'h00, "R9 move keeps flags");
    step(2'b01, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R6 add 7F+1");
    // R3 add with carry uses carry in
    step(2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h80, "R8 set carry");
    step(2'b10, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R3 addc");
    // R4 R6 0x80 - 1 with no borrow
    step(2'b00, 8'h00, 1'b1, 8'h80, 1'b1, 8'h00, "R8 clear flags");
    step(2'b11, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R4 R6 subb 80-1");
    // R4 R5 0 - 0 with borrow set
    step(2'b00, 8'h00, 1'b1, 8'h00, 1'b1, 8'h80, "R8 set borrow");
    step(2'b11, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, "R4 R5 subb 0-0-1");
    // R8 write all ones: bit1 reads 0, bit0 from accumulator
    step(2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 8'hFF, "R8 write FF");
    // R7 move 0xCC gives even parity, R9 flags held
    step(2'b00, 8'h00, 1'b1, 8'hCC, 1'b0, 8'h00, "R7 R9 move CC");
    // R10 collision: arithmetic flags win, bank and F0 from write
    step(2'b01, 8'h01, 1'b0, 8'h00, 1'b1, 8'hE4, "R10 collide");
    // R11 accumulator load loses to arithmetic
    step(2'b01, 8'h10, 1'b1, 8'h55, 1'b0, 8'h00, "R11 acc collide");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      step(op, 8'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
           ($urandom_range(0, 3) == 0), 8'($urandom),
           (op == 2'b01) ? "R2 R5 R6 rnd add" :
           (op == 2'b10) ? "R3 R5 R6 rnd addc" :
           (op == 2'b11) ? "R4 R5 R6 rnd subb" : "R7 R8 R9 rnd idle");
    end

    // R1 reset in mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset again", {8'h0, acc_q}, 16'h0000);
    chk("R1 reset psw", {8'h0, psw_q}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule